// File: doc/BRIEF.md
# Ready/Valid Synchronous Queue with Fall-Through and Pass-Through Options

This block is a single-clock first-in first-out queue that sits between a producer and a consumer. The producer presents an entry with a write-enable and sees a writable indication. The consumer sees a readable indication with the head entry beside it, and takes that entry by raising read-enable. An entry moves in a cycle where the enable and the matching indication are both high. Entries are held in a register array. Its read side is combinational and its write side is clocked, so one slot can be read and rewritten in the same cycle.

Two static parameters change the handshake rules. With `FLOW` set, an empty queue passes the producer's entry straight to the output in the same cycle. If the consumer takes that entry in the same cycle, it never enters storage. With `PIPE` set, a full queue still reports writable while the consumer is reading, so one entry leaves and one enters in the same cycle. Read-enable is taken as acceptance. An entry that is read out and then ignored by the consumer is gone, and the queue does not protect against this.

Top module: `rv_queue`

## Requirements
- R1: After a cycle with `rst` high, the queue is empty: `readable` is 0 while `wr_en` is 0, and `writable` is 1.
- R2: Apart from the fall-through case of R5, `readable` is 1 exactly when the queue holds at least one entry.
- R3: Apart from the pass-through case of R4, `writable` is 1 exactly when the queue holds fewer than `DEPTH` entries. A `wr_en` while `writable` is 0 stores nothing.
- R4: With `PIPE`=1, `writable` is 1 in any cycle where `rd_en` is 1, even when the queue is full. The entry leaving is the oldest one, and the entry arriving joins the tail.
- R5: With `FLOW`=1 and the queue empty, `wr_en`=1 makes `readable` 1 in the same cycle, and `rd_data` equals `wr_data`.
- R6: With `FLOW`=1, an empty queue that both accepts and delivers an entry in the same cycle is still empty in the next cycle.
- R7: Entries leave in the order they were accepted and with their data unchanged, including after the slot indices wrap past `DEPTH`-1. Occupancy rises by one on a write alone, falls by one on a read alone, and is unchanged when both happen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Producer offers `wr_data` |
| wr_data | input | WIDTH | Entry offered by the producer |
| writable | output | 1 | Queue can accept an entry this cycle |
| rd_en | input | 1 | Consumer takes the head entry this cycle |
| rd_data | output | WIDTH | Head entry, or the bypassed input under R5 |
| readable | output | 1 | An entry is available on `rd_data` |

## Verification
The assertions take for granted that `wr_en` and `rd_en` are known (not X) in every cycle after reset. They also assume the consumer really takes the entry in any cycle it raises `rd_en` while `readable` is high, because occupancy is checked against that handshake. The stimulus drives both enables at the falling edge from seeded random draws, so they are always 0 or 1. Four phases with different stall ratios push each of the four flow/pipe variants to full, to empty, and into sustained simultaneous read and write. A behavioural queue model takes every accepted read as consumed.

// File: rtl/rv_queue_pkg.sv
package rv_queue_pkg;

    // Width of a slot index for a given number of slots (at least one bit).
    function automatic int unsigned slot_bits(input int unsigned depth);
        return (depth <= 2) ? 1 : $clog2(depth);
    endfunction

    // Width of an occupancy counter able to hold 0..depth.
    function automatic int unsigned level_bits(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

endpackage

// File: rtl/rv_queue_store.sv
module rv_queue_store #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4,
    localparam int unsigned AW   = rv_queue_pkg::slot_bits(DEPTH)
) (
    input  logic             clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] slot_q [DEPTH];

    // Clocked write, one slot per generated register.
    for (genvar s = 0; s < DEPTH; s++) begin : g_slot
        always_ff @(posedge clk) begin
            if (we && (waddr == AW'(s))) begin
                slot_q[s] <= wdata;
            end
        end
    end

    // Combinational read: the old value is seen in the cycle the slot is rewritten.
    always_comb begin
        rdata = slot_q[0];
        for (int s = 0; s < DEPTH; s++) begin
            if (raddr == AW'(s)) rdata = slot_q[s];
        end
    end

endmodule

// File: rtl/rv_queue_ctrl.sv
module rv_queue_ctrl #(
    parameter int unsigned DEPTH = 4,
    parameter bit          FLOW  = 1'b0,
    parameter bit          PIPE  = 1'b0,
    localparam int unsigned AW   = rv_queue_pkg::slot_bits(DEPTH),
    localparam int unsigned LW   = rv_queue_pkg::level_bits(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    output logic          writable,
    output logic          readable,
    output logic          is_empty,
    output logic          store_we,
    output logic [AW-1:0] head_idx,
    output logic [AW-1:0] tail_idx
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [LW-1:0] FULL_LVL = LW'(DEPTH);

    typedef struct packed {
        logic [AW-1:0] head;
        logic [AW-1:0] tail;
        logic [LW-1:0] level;
    } ctrl_t;

    ctrl_t st_q, st_d;

    logic is_full, wr_fire, rd_fire, bypass;

    always_comb begin
        is_empty = (st_q.level == '0);
        is_full  = (st_q.level == FULL_LVL);

        readable = !is_empty;
        if (FLOW && wr_en) readable = 1'b1;
        writable = !is_full;
        if (PIPE && rd_en) writable = 1'b1;

        wr_fire  = wr_en && writable;
        rd_fire  = rd_en && readable;
        bypass   = FLOW && is_empty && wr_fire && rd_fire;
        store_we = wr_fire && !bypass;

        st_d = st_q;
        if (store_we) begin
            st_d.tail = (st_q.tail == LAST_IDX) ? '0 : st_q.tail + 1'b1;
        end
        if (rd_fire && !bypass) begin
            st_d.head = (st_q.head == LAST_IDX) ? '0 : st_q.head + 1'b1;
        end
        if (store_we && !(rd_fire && !bypass)) begin
            st_d.level = st_q.level + 1'b1;
        end else if (!store_we && rd_fire && !bypass) begin
            st_d.level = st_q.level - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign head_idx = st_q.head;
    assign tail_idx = st_q.tail;

    // R1: a reset cycle leaves nothing queued
    a_r1_reset_empty: assert property (@(posedge clk) $past(rst) |-> (st_q.level == '0));

    // R3: occupancy never exceeds the slot count
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        st_q.level <= FULL_LVL);

    // R3: with pass-through off, a full queue refuses the producer
    a_r3_full_refuses: assert property (@(posedge clk) disable iff (rst)
        (!PIPE && is_full) |-> !writable);

    // R4: with pass-through on, a read request opens the input even when full
    a_r4_pipe_accept: assert property (@(posedge clk) disable iff (rst)
        (PIPE && is_full && rd_en) |-> writable);

    // R6: a fall-through transfer on an empty queue leaves it empty
    a_r6_bypass_hold: assert property (@(posedge clk) disable iff (rst)
        (FLOW && is_empty && wr_en && rd_en) |=> (st_q.level == '0));

    // R7: write alone raises occupancy by one
    a_r7_level_up: assert property (@(posedge clk) disable iff (rst)
        (wr_en && writable && !(rd_en && readable)) |=> (st_q.level == $past(st_q.level) + 1'b1));

    // R7: read alone lowers occupancy by one
    a_r7_level_down: assert property (@(posedge clk) disable iff (rst)
        (rd_en && readable && !(wr_en && writable)) |=> (st_q.level == $past(st_q.level) - 1'b1));

endmodule

// File: rtl/rv_queue.sv
module rv_queue #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4,
    parameter bit          FLOW  = 1'b0,
    parameter bit          PIPE  = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [WIDTH-1:0] wr_data,
    output logic             writable,
    input  logic             rd_en,
    output logic [WIDTH-1:0] rd_data,
    output logic             readable
);

    localparam int unsigned AW = rv_queue_pkg::slot_bits(DEPTH);

    logic             is_empty, store_we;
    logic [AW-1:0]    head_idx, tail_idx;
    logic [WIDTH-1:0] stored;

    rv_queue_ctrl #(.DEPTH(DEPTH), .FLOW(FLOW), .PIPE(PIPE)) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .rd_en    (rd_en),
        .writable (writable),
        .readable (readable),
        .is_empty (is_empty),
        .store_we (store_we),
        .head_idx (head_idx),
        .tail_idx (tail_idx)
    );

    rv_queue_store #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_store (
        .clk   (clk),
        .we    (store_we),
        .waddr (tail_idx),
        .wdata (wr_data),
        .raddr (head_idx),
        .rdata (stored)
    );

    if (FLOW) begin : g_flow
        assign rd_data = is_empty ? wr_data : stored;
    end else begin : g_plain
        assign rd_data = stored;
    end

    // R5: fall-through presents the producer's entry on an empty queue
    a_r5_fallthrough: assert property (@(posedge clk) disable iff (rst)
        (FLOW && is_empty && wr_en) |-> (readable && rd_data == wr_data));

endmodule

// File: tb/rv_queue_test.sv
`timescale 1ns/1ps
module rv_queue_test;

    localparam int W   = 8;
    localparam int D   = 4;
    localparam int CYC = 3000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    int   errors = 0;
    int   checks = 0;

    always #2 clk = ~clk;   // 250 MHz

    task automatic check(input string tag, input int inst, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s variant%0d t=%0t actual=%0h expected=%0h", tag, inst, $time, act, exp);
        end
    endtask

    for (genvar v = 0; v < 4; v++) begin : g
        localparam bit F = (v % 2) == 1;
        localparam bit P = (v / 2) == 1;

        logic         wr_en = 1'b0, rd_en = 1'b0;
        logic [W-1:0] wr_data = '0;
        logic [W-1:0] rd_data;
        logic         writable, readable;
        logic         fin = 1'b0;

        rv_queue #(.WIDTH(W), .DEPTH(D), .FLOW(F), .PIPE(P)) uut (
            .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
            .writable(writable), .rd_en(rd_en), .rd_data(rd_data), .readable(readable)
        );

        initial begin
            logic [W-1:0] model[$];
            bit           prev_bypass = 1'b0;
            int           pw, pr;
            wait (!rst);
            @(negedge clk);
            #1;
            check("R1", v, {31'd0, readable}, 32'd0);
            check("R1", v, {31'd0, writable}, 32'd1);
            for (int c = 0; c < CYC; c++) begin
                bit    emp, ful, ex_rd, ex_wr, dw, dr;
                string rtag, wtag;
                case ((c / 250) % 4)
                    0:       begin pw = 90;  pr = 15;  end
                    1:       begin pw = 15;  pr = 90;  end
                    2:       begin pw = 55;  pr = 55;  end
                    default: begin pw = 100; pr = 100; end
                endcase
                @(negedge clk);
                wr_en   = ($urandom % 100) < pw;
                rd_en   = ($urandom % 100) < pr;
                wr_data = W'($urandom);
                #1;
                emp   = (model.size() == 0);
                ful   = (model.size() == D);
                ex_rd = !emp || (F && wr_en);
                ex_wr = !ful || (P && rd_en);
                rtag  = prev_bypass ? "R6" : ((F && emp && wr_en) ? "R5" : "R2");
                wtag  = (P && ful && rd_en) ? "R4" : "R3";
                check(rtag, v, {31'd0, readable}, {31'd0, ex_rd});
                check(wtag, v, {31'd0, writable}, {31'd0, ex_wr});
                if (ex_rd) begin
                    if (emp) check("R5", v, 32'(rd_data), 32'(wr_data));
                    else     check("R7", v, 32'(rd_data), 32'(model[0]));
                end
                dw = wr_en && ex_wr;
                dr = rd_en && ex_rd;
                prev_bypass = emp && dw && dr;
                if (!prev_bypass) begin
                    if (dr) void'(model.pop_front());
                    if (dw) model.push_back(wr_data);
                end
            end
            @(negedge clk);
            wr_en = 1'b0;
            rd_en = 1'b0;
            fin   = 1'b1;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        wait (g[0].fin && g[1].fin && g[2].fin && g[3].fin);
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired, actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule